// File: doc/BRIEF.md
# Banked Active Priority Register View

This block is the bus-facing access path to the active priority storage of one CPU interface in an interrupt controller. It owns two banks of 32-bit registers: a primary bank and a non-secure bank. Each bank holds one, two or four registers, and the count follows from the configured minimum binary point. Requests arrive as a single-cycle valid/write/address/data/secure strobe. A response comes back exactly one cycle later, with the read data held in a register.

The block filters every access. The filter looks at the required architecture revision, whether the access is secure, whether the security extension is present, and whether interrupt grouping is supported. A filtered access reads as zero and its write is dropped. A non-secure access to the primary window, made while the security extension is present, does not touch the primary bank. It is steered onto part of the non-secure bank instead. Which part depends on the minimum binary point: a whole register for small values, and a bit field of register 0 for larger ones.

The configuration inputs (revision, security extension, grouping) are sampled with each request. Setting and clearing bits on interrupt events is left to neighbouring logic.

Top module: `apr_bank_view`

## Requirements
- R1: After reset, every register of both banks is zero, and rsp_valid and rsp_rdata are zero.
- R2: rsp_valid is high exactly in the cycle after a cycle with req_valid high. rsp_rdata then carries the read value for a read, and zero for a write.
- R3: Word offsets 0xD0, 0xD4, 0xD8 and 0xDC select primary register (offset-0xD0)/4. A secure access, or any access when cfg_sec_ext is 0, reads and writes all 32 bits of that register.
- R4: Word offsets 0xE0 to 0xEC select non-secure register (offset-0xE0)/4. The access reaches all 32 bits of that register when cfg_groups is 1 and the access is secure or cfg_sec_ext is 0.
- R5: The 0xE0 window reads as zero and ignores writes when cfg_groups is 0. It does the same when cfg_sec_ext is 1 and req_secure is 0.
- R6: Any access reads as zero and ignores writes when cfg_rev is not 2. The same holds when the register index is at or above the register count. The count is 4 for MIN_BPR=0, 2 for MIN_BPR=1, and 1 for MIN_BPR=2 and MIN_BPR=3.
- R7: Some primary-window accesses are redirected: non-secure ones made while cfg_sec_ext is 1. For MIN_BPR=0, indices 0 and 1 reach all of non-secure registers 2 and 3. For MIN_BPR=1, index 0 reaches all of non-secure register 1.
- R8: In the same redirected case, MIN_BPR=2 maps index 0 onto bits [31:16] of non-secure register 0, and MIN_BPR=3 maps it onto bits [15:8]. A write changes only that field, taking it from the low bits of req_wdata. A read returns the field in the low bits, with all other bits zero.
- R9: A redirected primary-window index with no mapping reads as zero and ignores writes. For MIN_BPR=0 these are indices 2 and 3.
- R10: An address outside both windows, or one with req_addr[1:0] not zero, reads as zero and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_rev | input | 4 | Architecture revision; access is allowed only when this is 2 |
| cfg_sec_ext | input | 1 | Security extension present |
| cfg_groups | input | 1 | Interrupt grouping supported |
| req_valid | input | 1 | Request strobe, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset in the CPU interface map |
| req_wdata | input | 32 | Write data |
| req_secure | input | 1 | Access is secure |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata | output | 32 | Registered read data |

## Verification
Four instances, one for each minimum binary point, run side by side under every combination of revision, security extension, grouping support and access security. Each case writes a distinct value to every offset in and around both windows, including misaligned ones, and reads it back through the same view. After every write, a privileged, unfiltered view reads all eight registers. This catches a write that was dropped, one that landed in the wrong bank or index, or one that spilled outside its field. Comparing the four instances under the same stimulus separates the remap variants: whole-register redirection, the upper half-word field, and the middle byte field.

// File: rtl/apr_view_pkg.sv
package apr_view_pkg;

  localparam int unsigned APR_DW       = 32;
  localparam int unsigned APR_IDX_W    = 2;
  localparam logic [3:0]  REV_ALLOWED  = 4'd2;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_PRI  = 2'd1,
    TGT_NSB  = 2'd2
  } apr_tgt_e;

  typedef struct packed {
    apr_tgt_e              tgt;
    logic [APR_IDX_W-1:0]  idx;
    logic [APR_DW-1:0]     mask;
    logic [4:0]            lsb;
  } apr_route_t;

  // Registers needed to hold one bit per preemption level.
  function automatic int unsigned regs_for_bpr(input int unsigned min_bpr);
    int unsigned levels;
    levels = 128 >> min_bpr;
    return (levels + APR_DW - 1) / APR_DW;
  endfunction

endpackage

// File: rtl/apr_decode.sv
module apr_decode #(
  parameter int unsigned ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              win_pri,
  output logic              win_nsb,
  output logic [1:0]        idx
);
  localparam int unsigned TAG_W = ADDR_W - 4;
  localparam logic [TAG_W-1:0] PRI_TAG = TAG_W'(4'hD);
  localparam logic [TAG_W-1:0] NSB_TAG = TAG_W'(4'hE);

  logic aligned;

  always_comb begin
    aligned = (addr[1:0] == 2'b00);
    win_pri = aligned && (addr[ADDR_W-1:4] == PRI_TAG);
    win_nsb = aligned && (addr[ADDR_W-1:4] == NSB_TAG);
    idx     = addr[3:2];
  end
endmodule

// File: rtl/apr_route.sv
module apr_route
  import apr_view_pkg::*;
#(
  parameter int unsigned MIN_BPR = 0,
  parameter int unsigned NREGS   = 4
) (
  input  logic       win_pri,
  input  logic       win_nsb,
  input  logic [1:0] idx,
  input  logic       secure,
  input  logic [3:0] rev,
  input  logic       sec_ext,
  input  logic       groups,
  output apr_route_t route
);
  logic       redir_hit;
  logic [1:0] redir_idx;
  logic [31:0] redir_mask;
  logic [4:0]  redir_lsb;
  logic       idx_ok;
  logic       rev_ok;
  logic       ns_view;

  generate
    if (MIN_BPR == 0) begin : g_bpr0
      always_comb begin
        redir_hit  = (idx[1] == 1'b0);
        redir_idx  = {1'b1, idx[0]};
        redir_mask = 32'hFFFF_FFFF;
        redir_lsb  = 5'd0;
      end
    end else if (MIN_BPR == 1) begin : g_bpr1
      always_comb begin
        redir_hit  = (idx == 2'd0);
        redir_idx  = 2'd1;
        redir_mask = 32'hFFFF_FFFF;
        redir_lsb  = 5'd0;
      end
    end else if (MIN_BPR == 2) begin : g_bpr2
      always_comb begin
        redir_hit  = (idx == 2'd0);
        redir_idx  = 2'd0;
        redir_mask = 32'hFFFF_0000;
        redir_lsb  = 5'd16;
      end
    end else begin : g_bpr3
      always_comb begin
        redir_hit  = (idx == 2'd0);
        redir_idx  = 2'd0;
        redir_mask = 32'h0000_FF00;
        redir_lsb  = 5'd8;
      end
    end
  endgenerate

  always_comb begin
    idx_ok  = ({1'b0, idx} < 3'(NREGS));
    rev_ok  = (rev == REV_ALLOWED);
    ns_view = sec_ext && !secure;

    route.tgt  = TGT_NONE;
    route.idx  = idx;
    route.mask = 32'hFFFF_FFFF;
    route.lsb  = 5'd0;

    if (rev_ok && idx_ok) begin
      if (win_pri) begin
        if (!ns_view) begin
          route.tgt = TGT_PRI;
        end else if (redir_hit) begin
          route.tgt  = TGT_NSB;
          route.idx  = redir_idx;
          route.mask = redir_mask;
          route.lsb  = redir_lsb;
        end
      end else if (win_nsb && groups && !ns_view) begin
        route.tgt = TGT_NSB;
      end
    end
  end
endmodule

// File: rtl/apr_bank_store.sv
module apr_bank_store #(
  parameter int unsigned NREGS = 4,
  parameter int unsigned DW    = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [1:0]    widx,
  input  logic [DW-1:0] wmask,
  input  logic [DW-1:0] wdata,
  input  logic [1:0]    ridx,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [NREGS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREGS; i++) mem[i] <= '0;
    end else begin
      for (int i = 0; i < NREGS; i++) begin
        if (we && (widx == 2'(i))) mem[i] <= (mem[i] & ~wmask) | (wdata & wmask);
      end
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NREGS; i++) begin
      if (ridx == 2'(i)) rdata = mem[i];
    end
  end

  generate
    for (genvar g = 0; g < NREGS; g++) begin : g_chk
      // Without a write strobe for this entry, its contents must hold (R6, R9).
      assert_store_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !(we && widx == 2'(g)) |=> $stable(mem[g]));
      // A write never changes bits outside its field mask (R8).
      assert_field_keep_R8: assert property (@(posedge clk) disable iff (rst)
        (we && widx == 2'(g)) |=> ((mem[g] ^ $past(mem[g])) & ~$past(wmask)) == '0);
    end
  endgenerate
endmodule

// File: rtl/apr_bank_view.sv
module apr_bank_view
  import apr_view_pkg::*;
#(
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned MIN_BPR = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        cfg_rev,
  input  logic              cfg_sec_ext,
  input  logic              cfg_groups,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  input  logic              req_secure,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata
);
  localparam int unsigned NREGS   = regs_for_bpr(MIN_BPR);
  localparam int unsigned FIELD_W = (MIN_BPR == 2) ? 16 : (MIN_BPR >= 3) ? 8 : 32;

  logic       dec_pri;
  logic       dec_nsb;
  logic [1:0] dec_idx;
  apr_route_t route;
  logic [31:0] pri_rd;
  logic [31:0] nsb_rd;
  logic [31:0] wpos;
  logic [31:0] sel_rd;
  logic [31:0] rd_val;
  logic        we_pri;
  logic        we_nsb;
  logic        rsp_valid_q;
  logic [31:0] rsp_rdata_q;

  apr_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr    (req_addr),
    .win_pri (dec_pri),
    .win_nsb (dec_nsb),
    .idx     (dec_idx)
  );

  apr_route #(.MIN_BPR(MIN_BPR), .NREGS(NREGS)) u_route (
    .win_pri (dec_pri),
    .win_nsb (dec_nsb),
    .idx     (dec_idx),
    .secure  (req_secure),
    .rev     (cfg_rev),
    .sec_ext (cfg_sec_ext),
    .groups  (cfg_groups),
    .route   (route)
  );

  always_comb begin
    wpos   = req_wdata << route.lsb;
    we_pri = req_valid && req_write && (route.tgt == TGT_PRI);
    we_nsb = req_valid && req_write && (route.tgt == TGT_NSB);
    sel_rd = (route.tgt == TGT_PRI) ? pri_rd : nsb_rd;
    rd_val = (sel_rd & route.mask) >> route.lsb;
  end

  apr_bank_store #(.NREGS(NREGS), .DW(32)) u_pri_bank (
    .clk   (clk),
    .rst   (rst),
    .we    (we_pri),
    .widx  (route.idx),
    .wmask (route.mask),
    .wdata (wpos),
    .ridx  (route.idx),
    .rdata (pri_rd)
  );

  apr_bank_store #(.NREGS(NREGS), .DW(32)) u_nsb_bank (
    .clk   (clk),
    .rst   (rst),
    .we    (we_nsb),
    .widx  (route.idx),
    .wmask (route.mask),
    .wdata (wpos),
    .ridx  (route.idx),
    .rdata (nsb_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      rsp_valid_q <= req_valid;
      rsp_rdata_q <= (req_valid && !req_write && route.tgt != TGT_NONE) ? rd_val : '0;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rsp_rdata_q;

  assert_rsp_follows_R2: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  assert_rsp_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
  assert_write_rdata_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write) |=> rsp_rdata == '0);
  assert_bad_rev_raz_R6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && cfg_rev != REV_ALLOWED) |=> rsp_rdata == '0);
  assert_idx_range_raz_R6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && {1'b0, req_addr[3:2]} >= 3'(NREGS)) |=> rsp_rdata == '0);

  generate
    if (FIELD_W < 32) begin : g_field_chk
      assert_field_read_width_R8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && dec_pri && cfg_sec_ext && !req_secure)
        |=> rsp_rdata[31:FIELD_W] == '0);
    end
  endgenerate
endmodule

// File: tb/apr_bank_view_test.sv
module apr_bank_view_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  cfg_rev = 4'd2;
  logic        cfg_sec_ext = 1'b0;
  logic        cfg_groups = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_secure = 1'b1;
  logic        vld   [4];
  logic [31:0] rdata [4];

  logic [31:0] mp [4][4];
  logic [31:0] mn [4][4];

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  for (genvar g = 0; g < 4; g++) begin : gen_cfg
    apr_bank_view #(.ADDR_W(12), .MIN_BPR(g)) uut (
      .clk(clk), .rst(rst), .cfg_rev(cfg_rev), .cfg_sec_ext(cfg_sec_ext),
      .cfg_groups(cfg_groups), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_secure(req_secure),
      .rsp_valid(vld[g]), .rsp_rdata(rdata[g]));
  end

  task automatic check(input string tag, input int m, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s bpr=%0d addr=%h: actual %h expected %h", tag, m, req_addr, act, exp);
    end
  endtask

  function automatic string tag_of(int m, logic [11:0] a, bit sec);
    int nr = (m == 0) ? 4 : (m == 1) ? 2 : 1;
    int idx = int'(a[3:2]);
    bit al = (a[1:0] == 2'b00);
    bit pw = al && a[11:4] == 8'h0D;
    bit nw = al && a[11:4] == 8'h0E;
    if (!pw && !nw) return "R10";
    if (cfg_rev != 4'd2 || idx >= nr) return "R6";
    if (nw) return (!cfg_groups || (cfg_sec_ext && !sec)) ? "R5" : "R4";
    if (!(cfg_sec_ext && !sec)) return "R3";
    if (m == 0) return (idx < 2) ? "R7" : "R9";
    if (m == 1) return "R7";
    return "R8";
  endfunction

  // Reference model of the requirements; updates the expected banks on writes.
  task automatic model(input int m, input bit wr, input logic [11:0] a,
                       input logic [31:0] wd, input bit sec, output logic [31:0] exp);
    int nr = (m == 0) ? 4 : (m == 1) ? 2 : 1;
    int idx = int'(a[3:2]);
    bit al = (a[1:0] == 2'b00);
    bit pw = al && a[11:4] == 8'h0D;
    bit nw = al && a[11:4] == 8'h0E;
    bit nsv = cfg_sec_ext && !sec;
    int kind = 0;
    int ri = idx;
    int lo = 0;
    int w = 32;
    logic [31:0] fm;
    if (cfg_rev == 4'd2 && idx < nr) begin
      if (pw) begin
        if (!nsv) kind = 1;
        else begin
          case (m)
            0: if (idx < 2) begin kind = 2; ri = idx + 2; end
            1: if (idx == 0) begin kind = 2; ri = 1; end
            2: if (idx == 0) begin kind = 2; ri = 0; lo = 16; w = 16; end
            default: if (idx == 0) begin kind = 2; ri = 0; lo = 8; w = 8; end
          endcase
        end
      end else if (nw && cfg_groups && !nsv) kind = 2;
    end
    fm = (w == 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 32'h1);
    exp = '0;
    if (kind == 1) begin
      if (wr) mp[m][ri] = wd; else exp = mp[m][ri];
    end else if (kind == 2) begin
      if (wr) mn[m][ri] = (mn[m][ri] & ~(fm << lo)) | ((wd & fm) << lo);
      else exp = (mn[m][ri] >> lo) & fm;
    end
  endtask

  task automatic access(input bit wr, input logic [11:0] a, input logic [31:0] wd,
                        input bit sec, input string tag);
    logic [31:0] exp [4];
    for (int m = 0; m < 4; m++) model(m, wr, a, wd, sec, exp[m]);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd; req_secure = sec;
    @(negedge clk);
    req_valid = 1'b0;
    for (int m = 0; m < 4; m++) begin
      check("R2 valid", m, {31'b0, vld[m]}, 32'd1);
      if (wr) check("R2 write data", m, rdata[m], 32'd0);
      else    check(tag, m, rdata[m], exp[m]);
    end
  endtask

  task automatic clear_view_dump(input string tag);
    logic [3:0] sr = cfg_rev;
    logic ss = cfg_sec_ext, sg = cfg_groups;
    cfg_rev = 4'd2; cfg_sec_ext = 1'b0; cfg_groups = 1'b1;
    for (int r = 0; r < 4; r++) begin
      access(1'b0, 12'h0D0 + 12'(4 * r), 32'd0, 1'b1, tag);
      access(1'b0, 12'h0E0 + 12'(4 * r), 32'd0, 1'b1, tag);
    end
    cfg_rev = sr; cfg_sec_ext = ss; cfg_groups = sg;
  endtask

  initial begin
    for (int m = 0; m < 4; m++)
      for (int r = 0; r < 4; r++) begin mp[m][r] = '0; mn[m][r] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int m = 0; m < 4; m++) begin
      check("R1 valid", m, {31'b0, vld[m]}, 32'd0);
      check("R1 rdata", m, rdata[m], 32'd0);
    end
    clear_view_dump("R1");

    for (int c = 0; c < 16; c++) begin
      cfg_rev     = c[0] ? 4'd2 : 4'd1;
      cfg_sec_ext = c[1];
      cfg_groups  = c[2];
      for (int k = 0; k < 15; k++) begin
        logic [11:0] a;
        logic [31:0] wd;
        bit sec = c[3];
        a  = (k < 13) ? 12'h0C0 + 12'(4 * k) : (k == 13 ? 12'h0D1 : 12'h0E2);
        wd = 32'hA5C3_1E70 ^ (32'(c) << 24) ^ (32'(k + 1) * 32'h0103_0507);
        access(1'b1, a, wd, sec, tag_of(0, a, sec));
        for (int m = 0; m < 4; m++) begin
          logic [31:0] e;
          string t;
          t = tag_of(m, a, sec);
          model(m, 1'b0, a, 32'd0, sec, e);
        end
        access(1'b0, a, 32'd0, sec, tag_of(0, a, sec));
        clear_view_dump(tag_of(3, a, sec));
      end
    end

    @(negedge clk);
    for (int m = 0; m < 4; m++) check("R2 idle", m, {31'b0, vld[m]}, 32'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule